// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches. It holds two component predictors and a chooser. Component 0 is a bimodal table of 2-bit saturating counters indexed by fetch PC bits, which suits branches with a strong bias. Component 1 is a table of 2-bit counters indexed only by a global history register (GHR) of recent resolved outcomes, which captures correlation between branches. A third table of 2-bit chooser counters, indexed by PC, picks per branch which component to trust. A chooser MSB of 0 selects component 0 and an MSB of 1 selects component 1.

At fetch, the block looks up all three tables combinationally from the fetch PC and the current history. It returns the final direction and both component predictions. The fetch pipeline carries the component predictions along with the branch and hands them back at resolution, together with the branch PC and the real outcome. On that update the block does three things. It trains both components with the outcome. It shifts the outcome into the history. It moves the chooser toward the component that was right, but only when the two components disagreed.

The history is updated only at resolution. Global-table training uses the history value present at the update, which is the value the prediction saw when no other branch resolved between prediction and resolution.

Top module: `tourney_pred`

## Requirements
- R1: After reset every counter in all three tables reads 01, and the history is all zeros. Every PC therefore predicts not-taken from both components and the final output (all outputs 0).
- R2: The bimodal and chooser tables are indexed by PC bits [11:2]. PCs that differ only in bits [1:0], or only above bit 11, share an entry. PCs that differ in bits [11:2] do not.
- R3: Every counter is a 2-bit saturating counter. It increments on a taken outcome and stops at 11. It decrements on a not-taken outcome and stops at 00. A counter predicts taken exactly when its MSB is 1.
- R4: When the chooser MSB for the fetch PC is 0, the final prediction equals the component 0 output. When it is 1, the final prediction equals the component 1 output. When both components agree, the final prediction is their common value.
- R5: On an update, the chooser entry of the update PC moves only when the two returned component predictions differ. It increments if component 1 matched the outcome and decrements if component 0 matched.
- R6: Every valid update trains the bimodal entry of the update PC and the global entry selected by the current history with the outcome. This happens regardless of which component the chooser favours.
- R7: The global table is indexed by the 10-bit history. Each valid update shifts the outcome into history bit 0 (1 = taken) and drops the oldest bit.
- R8: While upd_valid_i is low, no table and no history bit changes, whatever the other update inputs carry.
- R9: Predictions are combinational. An update that lands on the entry being read in the same cycle is seen by the prediction only from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pred_pc_i | input | 32 | Fetch PC to predict |
| pred_taken_o | output | 1 | Final predicted direction (1 = taken) |
| pred_c0_o | output | 1 | Bimodal component prediction |
| pred_c1_o | output | 1 | Global component prediction |
| upd_valid_i | input | 1 | A resolved branch is presented this cycle |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome (1 = taken) |
| upd_c0_i | input | 1 | Component 0 prediction made earlier for this branch |
| upd_c1_i | input | 1 | Component 1 prediction made earlier for this branch |

## Verification
The bench targets the following corner cases:

- **Chooser that flips away from the bimodal side while the components disagree.** A design that selects on the wrong counter bit, or swaps the components, would report the bimodal direction where the global one is due.
- **Updates on which both components agree.** A chooser trained on every update would drift and change the selection on later fetches.
- **Counters driven past both ends.** A design that does not saturate would wrap from 11 to 00 and invert the prediction.
- **Aliasing PCs.** A wrong index slice would split PCs that should share an entry, or merge PCs that should not.
- **Idle cycles with garbage on the update inputs.** A design that trains or shifts history on them would corrupt later global predictions.
- **Same-cycle read and write of one entry.** A write-through design would show the new value one cycle early.

// File: rtl/tp_pkg.sv
package tp_pkg;
  parameter int unsigned CtrW = 2;
  typedef logic [CtrW-1:0] ctr_t;
  localparam ctr_t CtrMax  = '1;
  localparam ctr_t CtrMin  = '0;
  localparam ctr_t CtrInit = ctr_t'(1);

  function automatic ctr_t sat_step(input ctr_t c, input logic up);
    if (up) return (c == CtrMax) ? c : c + ctr_t'(1);
    return (c == CtrMin) ? c : c - ctr_t'(1);
  endfunction
endpackage

// File: rtl/ctr_table.sv
module ctr_table
  import tp_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter ctr_t        RST_VAL = CtrInit
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_up_i
);
  localparam int unsigned Depth = 1 << IDX_W;

  ctr_t ctr_q [Depth];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < Depth; i++) ctr_q[i] <= RST_VAL;
    end else if (upd_en_i) begin
      ctr_q[upd_idx_i] <= sat_step(ctr_q[upd_idx_i], upd_up_i);
    end
  end

  // read returns pre-update state
  assign rd_ctr_o = ctr_q[rd_idx_i];
endmodule

// File: rtl/hist_reg.sv
module hist_reg #(
  parameter int unsigned HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hist_q <= '0;
    else if (shift_en_i) hist_q <= {hist_q[HIST_W-2:0], bit_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
  import tp_pkg::*;
#(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned BIM_IDX_W  = 10,
  parameter int unsigned META_IDX_W = 10,
  parameter int unsigned GHR_W      = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  output logic            pred_c0_o,
  output logic            pred_c1_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic            upd_c0_i,
  input  logic            upd_c1_i
);
  localparam int unsigned PcLsb = 2;

  logic [GHR_W-1:0] ghr;
  ctr_t bim_ctr, glb_ctr, meta_ctr;
  logic meta_we, meta_up;

  // component 0: bimodal, PC indexed
  ctr_table #(.IDX_W(BIM_IDX_W), .RST_VAL(CtrInit)) u_bim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (pred_pc_i[PcLsb +: BIM_IDX_W]),
    .rd_ctr_o  (bim_ctr),
    .upd_en_i  (upd_valid_i),
    .upd_idx_i (upd_pc_i[PcLsb +: BIM_IDX_W]),
    .upd_up_i  (upd_taken_i)
  );

  // component 1: history indexed
  ctr_table #(.IDX_W(GHR_W), .RST_VAL(CtrInit)) u_glb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (ghr),
    .rd_ctr_o  (glb_ctr),
    .upd_en_i  (upd_valid_i),
    .upd_idx_i (ghr),
    .upd_up_i  (upd_taken_i)
  );

  // chooser trains only on disagreement, toward component 1 if it was right
  assign meta_we = upd_valid_i && (upd_c0_i != upd_c1_i);
  assign meta_up = (upd_c1_i == upd_taken_i);

  ctr_table #(.IDX_W(META_IDX_W), .RST_VAL(CtrInit)) u_meta (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (pred_pc_i[PcLsb +: META_IDX_W]),
    .rd_ctr_o  (meta_ctr),
    .upd_en_i  (meta_we),
    .upd_idx_i (upd_pc_i[PcLsb +: META_IDX_W]),
    .upd_up_i  (meta_up)
  );

  hist_reg #(.HIST_W(GHR_W)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (upd_valid_i),
    .bit_i      (upd_taken_i),
    .hist_o     (ghr)
  );

  assign pred_c0_o    = bim_ctr[CtrW-1];
  assign pred_c1_o    = glb_ctr[CtrW-1];
  assign pred_taken_o = meta_ctr[CtrW-1] ? pred_c1_o : pred_c0_o;
endmodule

// File: rtl/tourney_pred_chk.sv
module tourney_pred_chk #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned GHR_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PC_W-1:0]  pred_pc_i,
  input logic             pred_taken_o,
  input logic             pred_c0_o,
  input logic             pred_c1_o,
  input logic             upd_valid_i,
  input logic             upd_taken_i,
  input logic             upd_c0_i,
  input logic             upd_c1_i,
  input logic [GHR_W-1:0] ghr_i,
  input logic             meta_we_i
);
  p_agree_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_c0_o == pred_c1_o) |-> (pred_taken_o == pred_c0_o));

  p_meta_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_c0_i == upd_c1_i) |-> !meta_we_i);

  p_ghr_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> (ghr_i == {$past(ghr_i[GHR_W-2:0]), $past(upd_taken_i)}));

  p_ghr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghr_i));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> (!$stable(pred_pc_i) ||
                      $stable({pred_taken_o, pred_c0_o, pred_c1_o})));
endmodule

bind tourney_pred tourney_pred_chk #(.PC_W(PC_W), .GHR_W(GHR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pred_pc_i    (pred_pc_i),
  .pred_taken_o (pred_taken_o),
  .pred_c0_o    (pred_c0_o),
  .pred_c1_o    (pred_c1_o),
  .upd_valid_i  (upd_valid_i),
  .upd_taken_i  (upd_taken_i),
  .upd_c0_i     (upd_c0_i),
  .upd_c1_i     (upd_c1_i),
  .ghr_i        (ghr),
  .meta_we_i    (meta_we)
);

// File: tb/tourney_pred_bench.sv
`timescale 1ns/1ps
module tourney_pred_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pred_pc_i = '0;
  logic        pred_taken_o, pred_c0_o, pred_c1_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0, upd_c0_i = 1'b0, upd_c1_i = 1'b0;

  always #5 clk_i = ~clk_i;

  tourney_pred u_tourney_pred (.*);

  typedef struct {
    logic [31:0] pc;
    logic [2:0]  exp;
    string       tag;
  } item_t;
  item_t q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state, from the requirements
  int bim[1024], glb[1024], meta[1024];
  int ghr;

  function automatic int sat(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction
  function automatic int ix(logic [31:0] pc);
    return int'(pc[11:2]);
  endfunction
  function automatic bit m_c0(logic [31:0] pc);
    return bim[ix(pc)] >= 2;
  endfunction
  function automatic bit m_c1();
    return glb[ghr] >= 2;
  endfunction
  function automatic bit m_fin(logic [31:0] pc);
    return (meta[ix(pc)] >= 2) ? m_c1() : m_c0(pc);
  endfunction

  // monitor: compares expected items against outputs mid-cycle
  always @(negedge clk_i) begin
    while (q.size() > 0) begin
      item_t it;
      logic [2:0] act;
      it  = q.pop_front();
      act = {pred_taken_o, pred_c0_o, pred_c1_o};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s pc=%h {final,c0,c1} actual=%b expected=%b", it.tag, it.pc, act, it.exp);
      end
    end
  end

  // driver: one cycle; called just after a rising edge
  task automatic step(input logic [31:0] ppc, input bit chk, input bit v,
                      input logic [31:0] upc, input bit tk, input bit c0, input bit c1,
                      input string tag);
    item_t it;
    pred_pc_i   = ppc;
    upd_valid_i = v;
    upd_pc_i    = upc;
    upd_taken_i = tk;
    upd_c0_i    = c0;
    upd_c1_i    = c1;
    if (chk) begin
      it.pc  = ppc;
      it.exp = {m_fin(ppc), m_c0(ppc), m_c1()};
      it.tag = tag;
      q.push_back(it);
    end
    @(posedge clk_i);
    if (v) begin
      bim[ix(upc)] = sat(bim[ix(upc)], tk);
      glb[ghr]     = sat(glb[ghr], tk);
      if (c0 != c1) meta[ix(upc)] = sat(meta[ix(upc)], c1 == tk);
      ghr = ((ghr << 1) | int'(tk)) & 1023;
    end
    #1;
  endtask

  // update carrying the reference component predictions, plus a check at ppc
  task automatic train(input logic [31:0] ppc, input logic [31:0] upc, input bit tk, input string tag);
    step(ppc, 1, 1, upc, tk, m_c0(upc), m_c1(), tag);
  endtask

  task automatic peek(input logic [31:0] pc, input string tag);
    step(pc, 1, 0, 32'h0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin bim[i] = 1; glb[i] = 1; meta[i] = 1; end
    ghr = 0;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1 reset state
    peek(32'h0000_0000, "R1");
    peek(32'h0000_1234, "R1");
    peek(32'h0000_0FFC, "R1");

    // R3 saturation on bimodal entry at 0x100
    for (int i = 0; i < 4; i++) train(32'h100, 32'h100, 1, "R3 up");
    peek(32'h100, "R3 sat-high");
    train(32'h100, 32'h100, 0, "R3 down");
    peek(32'h100, "R3 msb");
    for (int i = 0; i < 4; i++) train(32'h100, 32'h100, 0, "R3 down");
    peek(32'h100, "R3 sat-low");
    for (int i = 0; i < 2; i++) train(32'h100, 32'h100, 1, "R3 up");

    // R2 aliasing
    peek(32'h101,  "R2 low bits");
    peek(32'h1100, "R2 high alias");
    peek(32'h104,  "R2 distinct");

    // R4 R5 chooser: push 0x200 toward component 1
    step(32'h200, 1, 1, 32'h200, 1, 0, 1, "R5 inc");
    step(32'h200, 1, 1, 32'h200, 1, 0, 1, "R5 inc");
    peek(32'h200, "R4 select c1");
    for (int i = 0; i < 3; i++) step(32'h200, 1, 1, 32'h200, 0, 1, 1, "R5 agree no-move");
    peek(32'h200, "R4 R5 still c1");
    step(32'h200, 1, 1, 32'h200, 1, 1, 0, "R5 dec");
    step(32'h200, 1, 1, 32'h200, 1, 1, 0, "R5 dec");
    peek(32'h200, "R4 select c0");

    // R6 components train while other side selected
    train(32'h200, 32'h200, 1, "R6");
    peek(32'h200, "R6");

    // R8 idle cycles with junk on update inputs
    for (int i = 0; i < 4; i++) step(32'h100, 1, 0, 32'h100, 1, 0, 1, "R8 idle");
    peek(32'h100, "R8 after idle");

    // R9 same-cycle read/write of one entry
    train(32'h300, 32'h300, 1, "R9 old value");
    train(32'h300, 32'h300, 1, "R9 old value");
    peek(32'h300, "R9 new value");

    // R7 history pattern then random mix
    for (int i = 0; i < 40; i++) train(32'h400, 32'h400, (i % 3) != 0, "R7 pattern");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] pp, up;
      bit tk, v;
      pp = {$urandom_range(0, 7), 2'b00} + ((i % 5 == 0) ? 32'h1000 : 32'h0);
      up = {$urandom_range(0, 7), 2'b00};
      tk = ($urandom_range(0, 3) != 0);
      v  = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 4) == 0)
        step(pp, 1, v, up, tk, 1'($urandom), 1'($urandom), "R4 R5 R6 R7 random");
      else
        step(pp, 1, v, up, tk, m_c0(up), m_c1(), "R4 R6 R7 R8 random");
    end

    upd_valid_i = 0;
    @(negedge clk_i); #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule